// File: doc/BRIEF.md
# Coprocessor Feature Access Trap Checker

This block keeps a 64-bit feature access control word and, for every instruction presented to it, decides at once whether that instruction must be trapped. It also decides which exception level takes the trap and which 6-bit exception class is reported. Each instruction arrives tagged with a class: floating-point/SIMD register use, vector-extension, or a trace system-register access. A trace access is further tagged by the state it runs in (64-bit, a 32-bit single-register move, or a 32-bit two-register move). Alongside the class come the current exception level, an EL2-enabled flag and the two hypervisor host-mode bits.

Three fields live in the control word: a 1-bit trace lock at bit 28, a 2-bit FP gate at bits 21:20 and a 2-bit vector gate at bits 17:16. Software writes the word through a synchronous write port, and only those five bits are kept. The trap decision itself is purely combinational, so a decode stage can use it in the same cycle. The reset value closes every gate, which means nothing runs until software opens it.

Top module: `feat_trap_unit`

## Requirements
- R1: Reset clears the trace lock, the FP gate and the vector gate, so `rd_data` reads 0 and an FP instruction at EL0 traps.
- R2: A write with `wr_en` high updates only bits 28, 21:20 and 17:16 on the next rising clock edge. Every other bit of `rd_data` always reads 0.
- R3: Each 2-bit gate decodes as follows: 11 traps nothing, 01 traps EL0 only, and 00 or 10 trap both EL0 and EL1.
- R4: With bit 28 set, every trace access class (`insn_cls` 3, 4 or 5) traps at EL0 and EL1. With bit 28 clear, trace accesses never trap.
- R5: A vector-extension instruction (`insn_cls` 2) is checked against the vector gate first and reports class 0x19. Only when the vector gate lets it through is it checked against the FP gate, and then it reports the FP class.
- R6: Instructions at EL2 or EL3 never trap. Classes 0, 6 and 7 never trap.
- R7: When `hyp_e2h` and `hyp_tge` are both 1, the control fields have no effect and nothing traps.
- R8: The target level `trap_el` is 2 when `el2_on` is 1, `hyp_e2h` is 0 and `hyp_tge` is 1. Otherwise it is 1. While `trap` is 0, `trap_el` and `trap_ec` are both 0.
- R9: Exception class codes are 0x18 for a 64-bit trace access, 0x05 for a 32-bit single-register trace move, 0x0C for a two-register trace move, and 0x19 for a vector-gate trap. An FP-gate trap reports 0x07 when it goes to EL1 and 0x00 when it goes to EL2. `insn_cls` encodes FP as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Current control word, reserved bits zero |
| cur_el | input | 2 | Current exception level 0..3 |
| insn_cls | input | 3 | Instruction class (0 none, 1 FP, 2 vector, 3 trace64, 4 trace32 single, 5 trace32 double) |
| el2_on | input | 1 | EL2 implemented and enabled |
| hyp_e2h | input | 1 | Hypervisor host-extension bit |
| hyp_tge | input | 1 | Hypervisor trap-general bit |
| trap | output | 1 | Instruction must be trapped |
| trap_el | output | 2 | Target level (1 or 2), 0 when no trap |
| trap_ec | output | 6 | Exception class code, 0 when no trap |

## Verification
The bench builds the block with its defaults: a 64-bit word, the vector gate and the trace lock both present, and the fields at bits 28, 21:20 and 17:16. That configuration reaches every pairing of the vector-over-FP precedence and every trace class code. Because all gate values, all levels, all classes and all hypervisor bit combinations fit in a small space, the random stream covers the cross of gate codes and contexts many times over. The directed cases fix the EL0-only encoding, the reserved bits, and the FP class code at both target levels.

// File: rtl/feat_trap_pkg.sv
package feat_trap_pkg;

  localparam logic [2:0] CLS_FP      = 3'd1;
  localparam logic [2:0] CLS_VEC     = 3'd2;
  localparam logic [2:0] CLS_TRC64   = 3'd3;
  localparam logic [2:0] CLS_TRC_ONE = 3'd4;
  localparam logic [2:0] CLS_TRC_TWO = 3'd5;

  localparam logic [5:0] EC_TRC64   = 6'h18;
  localparam logic [5:0] EC_TRC_ONE = 6'h05;
  localparam logic [5:0] EC_TRC_TWO = 6'h0C;
  localparam logic [5:0] EC_VEC     = 6'h19;
  localparam logic [5:0] EC_FP_LOW  = 6'h07;
  localparam logic [5:0] EC_FP_HYP  = 6'h00;

  typedef struct packed {
    logic       hit;
    logic [1:0] lvl;
    logic [5:0] ec;
  } trap_t;

  // Gate decode: 11 open, 01 closes EL0 only, 00/10 close EL0 and EL1
  function automatic logic gate_blocks(input logic [1:0] code, input logic [1:0] el);
    logic res;
    case (code)
      2'b11:   res = 1'b0;
      2'b01:   res = (el == 2'd0);
      default: res = 1'b1;
    endcase
    return res;
  endfunction

  function automatic logic is_trace(input logic [2:0] cls);
    return (cls == CLS_TRC64) || (cls == CLS_TRC_ONE) || (cls == CLS_TRC_TWO);
  endfunction

  function automatic logic [5:0] trace_ec(input logic [2:0] cls);
    logic [5:0] ec;
    case (cls)
      CLS_TRC_ONE: ec = EC_TRC_ONE;
      CLS_TRC_TWO: ec = EC_TRC_TWO;
      default:     ec = EC_TRC64;
    endcase
    return ec;
  endfunction

  function automatic logic [5:0] fp_ec(input logic [1:0] lvl);
    return (lvl == 2'd2) ? EC_FP_HYP : EC_FP_LOW;
  endfunction

endpackage

// File: rtl/feat_ctl_reg.sv
module feat_ctl_reg #(
  parameter int DATA_W    = 64,
  parameter int TRACE_BIT = 28,
  parameter int FP_LSB    = 20,
  parameter int VEC_LSB   = 16,
  parameter bit HAS_VEC   = 1'b1,
  parameter bit HAS_TRACE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              trace_lock,
  output logic [1:0]        fp_code,
  output logic [1:0]        vec_code
);

  logic [1:0] fp_q;
  logic       unused_wr;

  assign unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fp_q <= 2'b00;
    else if (wr_en) fp_q <= wr_data[FP_LSB +: 2];
  end
  assign fp_code = fp_q;

  generate
    if (HAS_VEC) begin : g_vec
      logic [1:0] vec_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     vec_q <= 2'b00;
        else if (wr_en) vec_q <= wr_data[VEC_LSB +: 2];
      end
      assign vec_code = vec_q;
    end else begin : g_no_vec
      assign vec_code = 2'b11;
    end

    if (HAS_TRACE) begin : g_trc
      logic trc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     trc_q <= 1'b0;
        else if (wr_en) trc_q <= wr_data[TRACE_BIT];
      end
      assign trace_lock = trc_q;
    end else begin : g_no_trc
      assign trace_lock = 1'b0;
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    rd_data[FP_LSB +: 2] = fp_q;
    if (HAS_VEC)   rd_data[VEC_LSB +: 2] = vec_code;
    if (HAS_TRACE) rd_data[TRACE_BIT]    = trace_lock;
  end

  // R2: without a write, the visible word holds its value
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(rd_data));
  // R2: a write lands in the FP field on the next edge
  assert_fp_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (rd_data[FP_LSB +: 2] == $past(wr_data[FP_LSB +: 2])));

endmodule

// File: rtl/feat_gate_eval.sv
module feat_gate_eval (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  input  logic [1:0] el,
  output logic       blocks
);
  import feat_trap_pkg::*;

  assign blocks = gate_blocks(code, el);

  // R3: an open gate never blocks
  assert_open_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'b11) |-> !blocks);
  // R3: the EL0-only code never blocks at EL1
  assert_el0_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'b01 && el == 2'd1) |-> !blocks);

endmodule

// File: rtl/feat_trap_route.sv
module feat_trap_route (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cls,
  input  logic       ctx_ok,
  input  logic       to_hyp,
  input  logic       vec_blk,
  input  logic       fp_blk,
  input  logic       trc_lock,
  output feat_trap_pkg::trap_t res
);
  import feat_trap_pkg::*;

  logic [1:0] lvl;
  logic       vec_hit;
  logic       fp_hit;
  logic       trc_hit;

  assign lvl     = to_hyp ? 2'd2 : 2'd1;
  assign vec_hit = ctx_ok && (cls == CLS_VEC) && vec_blk;
  assign fp_hit  = ctx_ok && ((cls == CLS_FP) || (cls == CLS_VEC)) && fp_blk && !vec_hit;
  assign trc_hit = ctx_ok && is_trace(cls) && trc_lock;

  always_comb begin
    res = '0;
    if (vec_hit) begin
      res.hit = 1'b1; res.lvl = lvl; res.ec = EC_VEC;
    end else if (fp_hit) begin
      res.hit = 1'b1; res.lvl = lvl; res.ec = fp_ec(lvl);
    end else if (trc_hit) begin
      res.hit = 1'b1; res.lvl = lvl; res.ec = trace_ec(cls);
    end
  end

  // R5: the vector gate wins over the FP gate
  assert_vec_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_hit |-> (res.hit && res.ec == EC_VEC));
  // R8: a trap goes to EL1 or EL2 only
  assert_target_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res.hit |-> (res.lvl == 2'd1 || res.lvl == 2'd2));
  // R8: quiet outputs when nothing traps
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !res.hit |-> (res.lvl == 2'd0 && res.ec == 6'd0));
  // R9: hypervisor-bound FP traps carry class 0
  assert_fp_hyp_ec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_hit && to_hyp) |-> (res.ec == EC_FP_HYP));

endmodule

// File: rtl/feat_trap_unit.sv
module feat_trap_unit #(
  parameter int DATA_W    = 64,
  parameter int TRACE_BIT = 28,
  parameter int FP_LSB    = 20,
  parameter int VEC_LSB   = 16,
  parameter bit HAS_VEC   = 1'b1,
  parameter bit HAS_TRACE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        cur_el,
  input  logic [2:0]        insn_cls,
  input  logic              el2_on,
  input  logic              hyp_e2h,
  input  logic              hyp_tge,
  output logic              trap,
  output logic [1:0]        trap_el,
  output logic [5:0]        trap_ec
);
  import feat_trap_pkg::*;

  localparam int NGATE = 2;

  logic             trace_lock;
  logic [1:0]       fp_code;
  logic [1:0]       vec_code;
  logic [1:0]       codes [NGATE];
  logic [NGATE-1:0] blk;
  logic             host_mode;
  logic             ctx_ok;
  logic             to_hyp;
  trap_t            res;

  feat_ctl_reg #(
    .DATA_W(DATA_W), .TRACE_BIT(TRACE_BIT), .FP_LSB(FP_LSB),
    .VEC_LSB(VEC_LSB), .HAS_VEC(HAS_VEC), .HAS_TRACE(HAS_TRACE)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .trace_lock(trace_lock),
    .fp_code(fp_code), .vec_code(vec_code)
  );

  assign codes[0] = fp_code;
  assign codes[1] = vec_code;

  generate
    for (genvar g = 0; g < NGATE; g++) begin : g_gate
      feat_gate_eval u_gate (
        .clk(clk), .rst_n(rst_n), .code(codes[g]), .el(cur_el), .blocks(blk[g])
      );
    end
  endgenerate

  assign host_mode = hyp_e2h && hyp_tge;
  assign ctx_ok    = !cur_el[1] && !host_mode;
  assign to_hyp    = el2_on && !hyp_e2h && hyp_tge;

  feat_trap_route u_route (
    .clk(clk), .rst_n(rst_n), .cls(insn_cls), .ctx_ok(ctx_ok),
    .to_hyp(to_hyp), .vec_blk(blk[1]), .fp_blk(blk[0]),
    .trc_lock(trace_lock), .res(res)
  );

  assign trap    = res.hit;
  assign trap_el = res.lvl;
  assign trap_ec = res.ec;

  // R6: upper levels run free
  assert_upper_el_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_el[1] |-> !trap);
  // R7: host mode disables every field
  assert_host_mode_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hyp_e2h && hyp_tge) |-> !trap);
  // R4: trace accesses never trap with the lock clear
  assert_trace_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_trace(insn_cls) && !rd_data[TRACE_BIT]) |-> !trap);

endmodule

// File: tb/tb_feat_trap_unit.sv
module tb_feat_trap_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [1:0]  cur_el = '0;
  logic [2:0]  insn_cls = '0;
  logic        el2_on = 1'b0, hyp_e2h = 1'b0, hyp_tge = 1'b0;
  logic        trap;
  logic [1:0]  trap_el;
  logic [5:0]  trap_ec;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;
  logic [63:0] shadow = '0;

  localparam logic [63:0] KEEP = 64'h0000_0000_1033_0000;

  always #4 clk = ~clk;

  feat_trap_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cur_el(cur_el), .insn_cls(insn_cls), .el2_on(el2_on), .hyp_e2h(hyp_e2h),
    .hyp_tge(hyp_tge), .trap(trap), .trap_el(trap_el), .trap_ec(trap_ec)
  );

  function automatic bit lets_run(bit [1:0] g, bit [1:0] el);
    return (g == 2'd3) || (g == 2'd1 && el == 2'd1);
  endfunction

  function automatic bit [8:0] model(bit [63:0] w, bit [1:0] el, bit [2:0] c,
                                     bit on, bit h, bit t);
    bit [1:0] tgt;
    bit [5:0] fpc;
    if (el >= 2 || (h && t)) return 9'd0;
    tgt = (on && !h && t) ? 2'd2 : 2'd1;
    fpc = (tgt == 2'd2) ? 6'h00 : 6'h07;
    if (c == 3'd2 && !lets_run(w[17:16], el)) return {1'b1, tgt, 6'h19};
    if ((c == 3'd1 || c == 3'd2) && !lets_run(w[21:20], el)) return {1'b1, tgt, fpc};
    if (w[28]) begin
      if (c == 3'd3) return {1'b1, tgt, 6'h18};
      if (c == 3'd4) return {1'b1, tgt, 6'h05};
      if (c == 3'd5) return {1'b1, tgt, 6'h0C};
    end
    return 9'd0;
  endfunction

  task automatic put(logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = ~d;
    shadow = d & KEEP;
  endtask

  task automatic probe(string tag, bit [1:0] el, bit [2:0] c, bit on, bit h, bit t);
    bit [8:0] exp_o;
    @(negedge clk);
    cur_el = el; insn_cls = c; el2_on = on; hyp_e2h = h; hyp_tge = t;
    #1;
    exp_o = model(shadow, el, c, on, h, t);
    n_vec++;
    if ({trap, trap_el, trap_ec} !== exp_o || rd_data !== shadow) begin
      n_bad++;
      $display("FAIL %s: got trap=%0d el=%0d ec=%h rd=%h, want trap=%0d el=%0d ec=%h rd=%h",
               tag, trap, trap_el, trap_ec, rd_data, exp_o[8], exp_o[7:6], exp_o[5:0], shadow);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    probe("R1 reset FP at EL0", 2'd0, 3'd1, 1'b0, 1'b0, 1'b0);
    probe("R1 reset trace", 2'd1, 3'd3, 1'b0, 1'b0, 1'b0);
    // R2: only the kept bits stick
    put('1);
    probe("R2 write all ones", 2'd0, 3'd0, 1'b0, 1'b0, 1'b0);
    put(64'hFFFF_FFFF_EFCC_FFFF);
    probe("R2 write complement", 2'd0, 3'd1, 1'b0, 1'b0, 1'b0);
    // R3: each gate code at EL0 and EL1
    for (int g = 0; g < 4; g++)
      for (int e = 0; e < 2; e++) begin
        put(64'(g) << 20 | 64'h3_0000);
        probe("R3 FP gate", 2'(e), 3'd1, 1'b0, 1'b0, 1'b0);
        put(64'(g) << 16 | 64'h30_0000);
        probe("R3 vector gate", 2'(e), 3'd2, 1'b0, 1'b0, 1'b0);
      end
    // R4 and R9: trace lock with each trace class
    for (int c = 3; c < 6; c++) begin
      put(64'h1033_0000);
      probe("R4 R9 trace locked", 2'd1, 3'(c), 1'b0, 1'b0, 1'b0);
      probe("R9 trace to hyp", 2'd0, 3'(c), 1'b1, 1'b0, 1'b1);
      put(64'h0033_0000);
      probe("R4 trace open", 2'd0, 3'(c), 1'b0, 1'b0, 1'b0);
    end
    // R5: vector gate open, FP gate closed -> FP class; both closed -> vector class
    put(64'h0003_0000);
    probe("R5 vec open fp closed", 2'd1, 3'd2, 1'b0, 1'b0, 1'b0);
    probe("R5 R9 fp class to hyp", 2'd1, 3'd2, 1'b1, 1'b0, 1'b1);
    put(64'h0000_0000);
    probe("R5 both closed", 2'd0, 3'd2, 1'b0, 1'b0, 1'b0);
    // R6: upper levels and unused classes
    probe("R6 EL2", 2'd2, 3'd1, 1'b1, 1'b0, 1'b1);
    probe("R6 EL3", 2'd3, 3'd2, 1'b0, 1'b0, 1'b0);
    probe("R6 class 7", 2'd0, 3'd7, 1'b0, 1'b0, 1'b0);
    // R7: host mode
    probe("R7 host mode", 2'd0, 3'd1, 1'b1, 1'b1, 1'b1);
    // R8: routing
    probe("R8 el2 off", 2'd0, 3'd1, 1'b0, 1'b0, 1'b1);
    probe("R8 e2h only", 2'd0, 3'd1, 1'b1, 1'b1, 1'b0);
    probe("R8 to hyp", 2'd1, 3'd1, 1'b1, 1'b0, 1'b1);
    // R9 random cross
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) put({$urandom, $urandom});
      probe("R9 random", 2'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule